// File: doc/BRIEF.md
# EDO DRAM access and refresh controller

This block sits between a synchronous host and a 4M x 4 asynchronous EDO DRAM. The host presents one word request at a time: a 22-bit word address, a read/write flag and a 4-bit write nibble. The controller splits the address into a row half and a column half and places them one after the other on a shared set of address pins. It generates the active-low row strobe, column strobe, write enable and output enable, captures the read nibble and reports completion.

Refresh runs in the background. An interval timer requests one CAS-before-RAS cycle per row period, so the whole array is covered once per refresh window. A pending refresh wins over a new host request. A refresh never cuts into an access that has already started. Every strobe duration is derived in clock cycles from picosecond timing parameters, each rounded up. A parameter chooses between the 11+11 row/column split and the 12+10 row/column split.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it is released, the four strobes are high, `dram_dq_oe` is low, `ready` is high and `done` is low.
- R2: With `REFRESH_4K`=0 the row pins carry address bits [21:11] at the row strobe fall and the column pins carry bits [10:0] at the column strobe fall, with pin 11 at 0. With `REFRESH_4K`=1 the split is bits [21:10] and bits [9:0].
- R3: For a read, `dram_oe_n` is low while the column strobe is low. The data pins are sampled in the last column-strobe cycle, and that nibble appears on `rdata` together with `done`.
- R4: For a write, `dram_we_n` is low and the write nibble is driven (`dram_dq_oe` high) at least one cycle before the column strobe falls. `dram_oe_n` stays high whenever `dram_we_n` is low.
- R5: With the default timing at 100 MHz, `done` is high in the 8th cycle after the accepting clock edge. If no refresh is pending, `ready` returns in the 11th cycle.
- R6: For an access with default timing, the row strobe stays low for 7 cycles and the column strobe for 2 cycles. Two row strobe falls are never closer than 11 cycles. The row strobe stays high for at least 2 cycles after it rises.
- R7: In a refresh the column strobe falls at least one cycle before the row strobe, `dram_we_n` stays high, and the row strobe is low for 6 cycles.
- R8: One refresh is started every refresh-window / row-count period, rounded up to whole cycles. With the bench setting this is every 100 cycles.
- R9: `ready` is low while a refresh is pending. Requests held back to back cannot delay refresh, and no refresh starts during an access.
- R10: `ready` falls in the cycle after acceptance and stays low until the access completes. `done` lasts one cycle. Changes to the request inputs while `ready` is low do not affect the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host request, accepted when `ready` is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address |
| req_wdata | input | 4 | Write nibble |
| ready | output | 1 | Controller can accept a request this cycle |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 4 | Last read nibble, valid from `done` |
| dram_addr | output | 12 | Multiplexed row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 4 | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 4 | Data returned by the DRAM |

## Verification
Every result falls a fixed number of cycles after the accepting clock edge:
- the row strobe falls on that edge;
- `done` and the read nibble arrive 8 cycles later;
- `ready` returns 11 cycles later when no refresh intervenes.

The bench counts falling clock edges from acceptance and samples each output at the exact count it is due. A memory model beside the design samples the strobes on rising edges, so it lags them by one cycle, and the bench reads the model's strobe-width and address records one edge after `done`. Refresh checks look at counts over windows that span many refresh intervals. The back-to-back ready latency is checked only right after a refresh, when no other refresh can be pending.

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl #(
  parameter int  ADDR_W            = 22,
  parameter int  DATA_W            = 4,
  parameter int  PIN_W             = 12,
  parameter bit  REFRESH_4K        = 1'b0,
  parameter int  CLK_PS            = 10000,
  parameter int  T_RC_PS           = 104000,
  parameter int  T_RAC_PS          = 60000,
  parameter int  T_CAC_PS          = 15000,
  parameter int  T_CAS_PS          = 10000,
  parameter int  REFRESH_WINDOW_NS = 64000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [PIN_W-1:0]  dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);

  localparam int ROW_W   = ADDR_W / 2 + (REFRESH_4K ? 1 : 0);
  localparam int COL_W   = ADDR_W - ROW_W;

  localparam int C_RC    = (T_RC_PS  + CLK_PS - 1) / CLK_PS;
  localparam int C_RAC   = (T_RAC_PS + CLK_PS - 1) / CLK_PS;
  localparam int C_CAC   = (T_CAC_PS + CLK_PS - 1) / CLK_PS;
  localparam int C_CAS   = (T_CAS_PS + CLK_PS - 1) / CLK_PS;

  localparam int C_CASW  = (C_CAC > C_CAS) ? C_CAC : C_CAS;
  localparam int C_RCD   = (C_RAC > C_CAC) ? C_RAC - C_CAC : 1;
  localparam int C_RREF  = (C_RAC > C_CASW) ? C_RAC : C_CASW;
  localparam int ACC_LOW = C_RCD + 1 + C_CASW;
  localparam int PRE_ACC = (C_RC > ACC_LOW + 1) ? C_RC - ACC_LOW - 1 : 1;
  localparam int PRE_REF = (C_RC > C_RREF + 1) ? C_RC - C_RREF - 1 : 1;

  localparam int CNT_MAX = (C_RC > C_RREF) ? C_RC : C_RREF;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  localparam longint REF_DIV = (longint'(1) << ROW_W) * longint'(CLK_PS);
  localparam int REFI    = int'((longint'(REFRESH_WINDOW_NS) * 1000 + REF_DIV - 1) / REF_DIV);
  localparam int REFI_W  = $clog2(REFI + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_ROW, S_COL, S_CAS, S_PRE, S_RCAS, S_RREF
  } state_t;

  state_t              state;
  logic [CNT_W-1:0]    cnt, lim;
  logic                last;
  logic                op_we, is_ref;
  logic [ADDR_W-1:0]   op_addr;
  logic [DATA_W-1:0]   op_data;
  logic [REFI_W-1:0]   ref_cnt;
  logic                ref_pend, ref_tick;

  always_comb begin
    case (state)
      S_ROW:   lim = CNT_W'(C_RCD);
      S_CAS:   lim = CNT_W'(C_CASW);
      S_PRE:   lim = is_ref ? CNT_W'(PRE_REF) : CNT_W'(PRE_ACC);
      S_RREF:  lim = CNT_W'(C_RREF);
      default: lim = CNT_W'(1);
    endcase
  end

  assign last     = (cnt == lim - CNT_W'(1));
  assign ref_tick = (ref_cnt == REFI_W'(REFI - 1));
  assign ready    = (state == S_IDLE) && !ref_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      op_we    <= 1'b0;
      op_addr  <= '0;
      op_data  <= '0;
      is_ref   <= 1'b0;
      rdata    <= '0;
      done     <= 1'b0;
      ref_cnt  <= '0;
      ref_pend <= 1'b0;
    end else begin
      done    <= 1'b0;
      cnt     <= last ? '0 : cnt + CNT_W'(1);
      ref_cnt <= ref_tick ? '0 : ref_cnt + REFI_W'(1);
      if (state == S_IDLE && ref_pend) ref_pend <= 1'b0;
      if (ref_tick) ref_pend <= 1'b1;
      case (state)
        S_IDLE:
          if (ref_pend) begin
            state  <= S_RCAS;
            is_ref <= 1'b1;
          end else if (req) begin
            state   <= S_ROW;
            is_ref  <= 1'b0;
            op_we   <= req_we;
            op_addr <= req_addr;
            op_data <= req_wdata;
          end
        S_ROW:  if (last) state <= S_COL;
        S_COL:  state <= S_CAS;
        S_CAS:
          if (last) begin
            if (!op_we) rdata <= dram_dq_in;
            done  <= 1'b1;
            state <= S_PRE;
          end
        S_PRE:  if (last) state <= S_IDLE;
        S_RCAS: state <= S_RREF;
        S_RREF: if (last) state <= S_PRE;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic col_phase;
  assign col_phase   = (state == S_COL) || (state == S_CAS);

  assign dram_ras_n  = !((state == S_ROW) || col_phase || (state == S_RREF));
  assign dram_cas_n  = !((state == S_CAS) || (state == S_RCAS) || (state == S_RREF));
  assign dram_we_n   = !(op_we && col_phase);
  assign dram_oe_n   = !(!op_we && state == S_CAS);
  assign dram_dq_oe  = op_we && col_phase;
  assign dram_dq_out = op_data;

  assign dram_addr = (state == S_ROW) ? PIN_W'(op_addr[ADDR_W-1:COL_W]) :
                     col_phase        ? PIN_W'(op_addr[COL_W-1:0])      : '0;

endmodule

// File: rtl/edo_dram_ctrl_checker.sv
module edo_dram_ctrl_checker (
  input logic clk,
  input logic rst_n,
  input logic req,
  input logic ready,
  input logic done,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe
);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ras_n && cas_n));

  p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ready) |=> !ready);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_early_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n && !we_n) |-> $past(!we_n && dq_oe));

  p_write_no_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);

  p_read_oe_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!cas_n && !ras_n && we_n));

  p_cbr_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> ($past(!cas_n) && we_n));

  p_precharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n);

endmodule

bind edo_dram_ctrl edo_dram_ctrl_checker u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .req   (req),
  .ready (ready),
  .done  (done),
  .ras_n (dram_ras_n),
  .cas_n (dram_cas_n),
  .we_n  (dram_we_n),
  .oe_n  (dram_oe_n),
  .dq_oe (dram_dq_oe)
);

// File: tb/edo_dram_ctrl_bench.sv
module edo_dram_model #(parameter int COL_W = 11) (
  input  logic        clk,
  input  logic [11:0] addr,
  input  logic        ras_n,
  input  logic        cas_n,
  input  logic        we_n,
  input  logic        oe_n,
  input  logic [3:0]  dq_out,
  input  logic        dq_oe,
  output logic [3:0]  dq_in
);
  logic [3:0] mem [logic [23:0]];
  logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, p_dqoe = 1'b0;
  logic [11:0] last_row = '0, last_col = '0;
  logic [3:0]  rd_val = '0;
  logic [23:0] key;
  int ref_count = 0, ref_lead = 0, ras_run = 0, cas_run = 0;
  int last_ras_low = 0, last_cas_low = 0, rc_run = 0, min_rc = 1000;
  bit seen = 0, ref_we_ok = 0, early_ok = 0, rd_oe_ok = 0;

  always @(posedge clk) begin
    rc_run++;
    if (p_ras && !ras_n) begin
      if (seen && rc_run < min_rc) min_rc = rc_run;
      rc_run = 0;
      seen = 1;
      if (!cas_n) begin
        ref_count++;
        ref_lead  = cas_run;
        ref_we_ok = we_n;
      end else last_row = addr;
    end
    if (!p_ras && ras_n) last_ras_low = ras_run;
    if (p_cas && !cas_n && !ras_n) begin
      last_col = addr;
      key = (24'(last_row) << COL_W) | 24'(last_col);
      if (!we_n) begin
        mem[key] = dq_out;
        early_ok = !p_we && p_dqoe && oe_n;
      end else begin
        rd_val   = mem.exists(key) ? mem[key] : 4'h0;
        rd_oe_ok = !oe_n;
      end
    end
    if (!p_cas && cas_n) last_cas_low = cas_run;
    ras_run = ras_n ? 0 : ras_run + 1;
    cas_run = cas_n ? 0 : cas_run + 1;
    p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_dqoe = dq_oe;
  end

  assign dq_in = (!oe_n && !cas_n) ? rd_val : 4'h0;
endmodule

module edo_dram_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_we = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;

  logic ready, done, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [3:0] rdata, dq_out, dq_in;
  logic [11:0] addr;
  logic ready4, done4, ras4, cas4, we4, oe4, dqoe4;
  logic [3:0] rdata4, dqo4, dqi4;
  logic [11:0] addr4;

  int checks = 0, fails = 0, lat_done = 0, lat_ready = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  edo_dram_ctrl #(.REFRESH_4K(1'b0), .REFRESH_WINDOW_NS(2048000)) u_edo_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .done(done), .rdata(rdata),
    .dram_addr(addr), .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
    .dram_oe_n(oe_n), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

  edo_dram_ctrl #(.REFRESH_4K(1'b1), .REFRESH_WINDOW_NS(4096000)) u_edo_dram_ctrl_4k (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready4), .done(done4), .rdata(rdata4),
    .dram_addr(addr4), .dram_ras_n(ras4), .dram_cas_n(cas4), .dram_we_n(we4),
    .dram_oe_n(oe4), .dram_dq_out(dqo4), .dram_dq_oe(dqoe4), .dram_dq_in(dqi4));

  edo_dram_model #(.COL_W(11)) m2 (.clk(clk), .addr(addr), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));
  edo_dram_model #(.COL_W(10)) m4 (.clk(clk), .addr(addr4), .ras_n(ras4), .cas_n(cas4),
    .we_n(we4), .oe_n(oe4), .dq_out(dqo4), .dq_oe(dqoe4), .dq_in(dqi4));

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic do_op(input logic we, input logic [21:0] a, input logic [3:0] d);
    int n;
    while (!ready) @(negedge clk);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; req_we = ~we; req_addr = ~a; req_wdata = ~d;
    chk(!ready && !ready4, "R10 ready low after accept", int'(ready), 0);
    n = 1;
    while (!done && n < 60) begin @(negedge clk); n++; end
    lat_done = n;
    chk(done4 == done, "R2 both splits finish together", int'(done4), int'(done));
    @(negedge clk); n++;
    chk(!done, "R10 done lasts one cycle", int'(done), 0);
    chk(m2.last_row == 12'(a >> 11) && m2.last_col == 12'(a[10:0]),
        "R2 11/11 split row", int'(m2.last_row), int'(a >> 11));
    chk(m4.last_row == 12'(a >> 10) && m4.last_col == 12'(a[9:0]),
        "R2 12/10 split row", int'(m4.last_row), int'(a >> 10));
    chk(m2.last_ras_low == 7 && m2.last_cas_low == 2, "R6 access strobe widths",
        m2.last_ras_low * 10 + m2.last_cas_low, 72);
    if (we) chk(m2.early_ok && m4.early_ok, "R4 early write", int'(m2.early_ok), 1);
    else    chk(m2.rd_oe_ok && m4.rd_oe_ok, "R3 oe low with column strobe", int'(m2.rd_oe_ok), 1);
    while (!ready && n < 300) begin @(negedge clk); n++; end
    lat_ready = n;
  endtask

  localparam int NV = 8;
  localparam logic [30:0] VEC [NV] = '{
    {1'b1, 22'h000000, 4'h5, 4'h0},
    {1'b1, 22'h3FFFFF, 4'hA, 4'h0},
    {1'b1, 22'h155555, 4'h3, 4'h0},
    {1'b1, 22'h2AAAAA, 4'hC, 4'h0},
    {1'b0, 22'h3FFFFF, 4'h0, 4'hA},
    {1'b0, 22'h000000, 4'h0, 4'h5},
    {1'b0, 22'h2AAAAA, 4'h0, 4'hC},
    {1'b0, 22'h155555, 4'h0, 4'h3}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int c0;
    bit all_ok;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n && !dq_oe && !done, "R1 strobes idle in reset", int'(ras_n), 1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n && !dq_oe && ready && !done,
        "R1 idle after reset", int'(ready), 1);

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][30], VEC[i][29:8], VEC[i][7:4]);
      chk(lat_done == 8, "R5 done latency", lat_done, 8);
      chk(lat_ready >= 11, "R5 ready latency lower bound", lat_ready, 11);
      if (!VEC[i][30]) begin
        chk(rdata == VEC[i][3:0], "R3 read data 11/11", int'(rdata), int'(VEC[i][3:0]));
        chk(rdata4 == VEC[i][3:0], "R3 read data 12/10", int'(rdata4), int'(VEC[i][3:0]));
      end
    end

    c0 = m2.ref_count;
    while (m2.ref_count == c0) @(negedge clk);
    chk(m2.ref_lead >= 1 && m2.ref_we_ok, "R7 column strobe leads, write high", m2.ref_lead, 1);
    repeat (8) @(negedge clk);
    chk(m2.last_ras_low == 6, "R7 refresh row strobe width", m2.last_ras_low, 6);
    do_op(1'b1, 22'h0ABCDE, 4'h9);
    chk(lat_ready == 11, "R5 ready latency without refresh", lat_ready, 11);
    do_op(1'b0, 22'h0ABCDE, 4'h0);
    chk(rdata == 4'h9 && rdata4 == 4'h9, "R10 inputs changed while busy ignored", int'(rdata), 9);

    c0 = m2.ref_count;
    repeat (1000) @(negedge clk);
    chk(m2.ref_count - c0 >= 9 && m2.ref_count - c0 <= 11, "R8 refresh rate",
        m2.ref_count - c0, 10);
    chk(m4.ref_count == m2.ref_count, "R8 refresh rate 12/10", m4.ref_count, m2.ref_count);

    c0 = m2.ref_count;
    all_ok = 1;
    for (int k = 0; k < 40; k++) begin
      do_op(1'b0, 22'h000000, 4'h0);
      if (rdata != 4'h5) all_ok = 0;
    end
    chk(all_ok, "R9 back-to-back reads intact", int'(all_ok), 1);
    chk(m2.ref_count - c0 >= 3, "R9 refresh not starved", m2.ref_count - c0, 4);
    chk(m2.min_rc >= 11 && m4.min_rc >= 11, "R6 row cycle spacing", m2.min_rc, 11);

    c0 = m2.ref_count;
    while (m2.ref_count == c0) begin
      @(negedge clk);
      if (ready && !ras_n) all_ok = 0;
    end
    chk(all_ok && !ready, "R9 ready low during refresh", int'(ready), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule